// File: doc/BRIEF.md
# Time-of-Day Counter with Command Engine

The block keeps a precision time of day for stamping packets. It holds a 48-bit seconds count, a 32-bit nanoseconds count and a 32-bit fraction of a nanosecond in units of 2^-32 ns. On every clock it adds a programmable step to that time. A frequency trim can raise or lower the step by up to half a nanosecond. Nanoseconds roll over into seconds at one billion.

Software reaches the block through a 16-bit register port with separate write and read strobes. It programs the step and fills a staging time. It then fires one-shot commands that load the time, trim the rate, add or subtract the staged offset, or sample the running time into one of two capture slots. A rising edge on the event input fires whatever command is currently coded, exactly as the software trigger does, and it cannot be masked. The event input must already be synchronous to `clk`.

The running time is also driven on output ports for the timestamping logic. The asynchronous reset is released through a two-flop synchronizer, so the registers leave reset two clock edges after `rst_n` rises.

Top module: `tod_counter`

## Requirements
- R1: After reset, the following register values read back: run control (address 0) reads 0, status (address 2) reads 0, and the step nanoseconds register (address 3) reads 3. The step fraction reads 0 and the time outputs are all zero. While bit 0 of address 0 is 0, the time is held at zero and no command changes it.
- R2: While running, each clock adds the step to the time. The step is the nanoseconds register (address 3) plus the 32-bit step fraction (high half at address 4, low half at address 5). The step fraction is a two's-complement offset in 2^-32 ns, so ns 4 with fraction 0xC000_0000 advances 3.75 ns per clock.
- R3: When nanoseconds reach 1,000,000,000 they drop by that amount and seconds rise by one. The nanoseconds output never reads 1,000,000,000 or more.
- R4: The command register is at address 1. Bits [4:2] hold the code: 0 load, 1 frequency trim, 2 add, 3 subtract, 4 capture, 5 to 7 no-op. Bit 8 holds a phase-enable flag. Writing bit 0 as 1 fires the code being written once, on that write's clock edge. Bit 0 is not stored and reads back 0.
- R5: Load replaces the time with the staging value on the firing edge, with no step added in that cycle. The staging value is at addresses 8 to 14: seconds high, middle and low, nanoseconds high and low, fraction high and low. Load also clears bit 8 of the command register.
- R6: Frequency trim copies the staged fraction into a signed trim. From then on the trim is added to the step on every clock, in 2^-32 ns units.
- R7: Add and subtract give the stepped time plus or minus the staged seconds and nanoseconds on the firing edge, with a carry or borrow across the one-billion boundary. The fraction is left unchanged.
- R8: A 0-to-1 change on `evt_in` fires the stored code once. Holding `evt_in` high does not fire it again. No register bit can mask it.
- R9: Capture stores the time as it stood before the firing edge. It fills slot 0 when slot 0 is empty, otherwise slot 1, and overwrites slot 1 when both are full. Status bit 0 shows slot 0 is valid and bit 1 shows slot 1 is valid.
- R10: Slot 0 is read at addresses 16 to 22 and slot 1 at addresses 24 to 30, using the staging field order. Read data appears one clock after the read strobe. Reading a slot's low fraction half (address 22 or 30) clears that slot's valid bit.
- R11: Codes 5, 6 and 7 leave the time stepping as if nothing had fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 16 | Read data, valid the clock after rd_en |
| evt_in | input | 1 | External event, rising edge fires the stored code |
| tod_sec | output | 48 | Running seconds |
| tod_ns | output | 32 | Running nanoseconds |
| tod_frac | output | 32 | Running fraction of a nanosecond |

## Verification
Register writes, command effects and the event all take effect on the clock edge at which the strobe or the event's rising edge is seen. The time outputs therefore show a load, add or subtract at the next falling edge. A capture holds the time that was visible just before that edge. Read data and read-to-clear take effect one edge after `rd_en`.

The bench drives every input on a falling edge and samples outputs on the following falling edge. Where a result depends on the current time, it reads the time at the falling edge where it issues the command, and computes the expected value as that time plus one step plus or minus the staged offset. Rate checks count whole clock periods after an exact load.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int SEC_W  = 48;
  localparam int NS_W   = 32;
  localparam int FR_W   = 32;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 5;
  localparam int NS_PER_SEC = 1_000_000_000;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [NS_W-1:0]  ns;
    logic [FR_W-1:0]  fr;
  } tod_t;

  typedef enum logic [2:0] {
    CMD_LOAD = 3'd0,
    CMD_FREQ = 3'd1,
    CMD_INC  = 3'd2,
    CMD_DEC  = 3'd3,
    CMD_CAP  = 3'd4,
    CMD_NOP  = 3'd7
  } cmd_e;

  localparam logic [ADDR_W-1:0] A_CTRL    = 5'd0;
  localparam logic [ADDR_W-1:0] A_CMD     = 5'd1;
  localparam logic [ADDR_W-1:0] A_STAT    = 5'd2;
  localparam logic [ADDR_W-1:0] A_STEP_NS = 5'd3;
  localparam logic [ADDR_W-1:0] A_STEP_FH = 5'd4;
  localparam logic [ADDR_W-1:0] A_STEP_FL = 5'd5;
  localparam logic [ADDR_W-1:0] A_CLR0    = 5'd22;
  localparam logic [ADDR_W-1:0] A_CLR1    = 5'd30;

  // 16-bit view of one time field; index order: sec hi/mid/lo, ns hi/lo, frac hi/lo
  function automatic logic [REG_W-1:0] tod_field(tod_t t, logic [2:0] idx);
    logic [REG_W-1:0] v;
    case (idx)
      3'd0:    v = t.sec[47:32];
      3'd1:    v = t.sec[31:16];
      3'd2:    v = t.sec[15:0];
      3'd3:    v = t.ns[31:16];
      3'd4:    v = t.ns[15:0];
      3'd5:    v = t.fr[31:16];
      3'd6:    v = t.fr[15:0];
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic tod_t tod_set_field(tod_t t, logic [2:0] idx, logic [REG_W-1:0] v);
    tod_t r;
    r = t;
    case (idx)
      3'd0:    r.sec[47:32] = v;
      3'd1:    r.sec[31:16] = v;
      3'd2:    r.sec[15:0]  = v;
      3'd3:    r.ns[31:16]  = v;
      3'd4:    r.ns[15:0]   = v;
      3'd5:    r.fr[31:16]  = v;
      3'd6:    r.fr[15:0]   = v;
      default: r = t;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/tod_step.sv
module tod_step
  import tod_pkg::*;
#(
  parameter int STEP_NS_W = 16
) (
  input  tod_t                 cur,
  input  logic [STEP_NS_W-1:0] step_ns,
  input  logic [FR_W-1:0]      step_fr,
  input  logic [FR_W-1:0]      trim,
  output tod_t                 nxt
);
  localparam int ACC_W = NS_W + FR_W;

  logic [ACC_W-1:0] step_fx;
  logic [ACC_W-1:0] acc;
  logic [NS_W-1:0]  ns_raw;

  always_comb begin
    // whole ns, plus signed fraction offset, plus signed rate trim
    step_fx = {{(NS_W-STEP_NS_W){1'b0}}, step_ns, {FR_W{1'b0}}}
            + {{NS_W{step_fr[FR_W-1]}}, step_fr}
            + {{NS_W{trim[FR_W-1]}}, trim};
    acc     = {cur.ns, cur.fr} + step_fx;
    ns_raw  = acc[ACC_W-1:FR_W];
    nxt.fr  = acc[FR_W-1:0];
    if (ns_raw >= NS_W'(NS_PER_SEC)) begin
      nxt.ns  = ns_raw - NS_W'(NS_PER_SEC);
      nxt.sec = cur.sec + SEC_W'(1);
    end else begin
      nxt.ns  = ns_raw;
      nxt.sec = cur.sec;
    end
  end
endmodule

// File: rtl/tod_adjust.sv
module tod_adjust
  import tod_pkg::*;
(
  input  tod_t base,
  input  tod_t delta,
  input  logic sub,
  output tod_t res
);
  logic [NS_W:0] ns_s;

  always_comb begin
    res.fr = base.fr;
    if (!sub) begin
      ns_s = {1'b0, base.ns} + {1'b0, delta.ns};
      if (ns_s >= (NS_W+1)'(NS_PER_SEC)) begin
        res.ns  = NS_W'(ns_s - (NS_W+1)'(NS_PER_SEC));
        res.sec = base.sec + delta.sec + SEC_W'(1);
      end else begin
        res.ns  = ns_s[NS_W-1:0];
        res.sec = base.sec + delta.sec;
      end
    end else begin
      ns_s = {1'b0, base.ns} - {1'b0, delta.ns};
      if (ns_s[NS_W]) begin
        res.ns  = NS_W'(ns_s + (NS_W+1)'(NS_PER_SEC));
        res.sec = base.sec - delta.sec - SEC_W'(1);
      end else begin
        res.ns  = ns_s[NS_W-1:0];
        res.sec = base.sec - delta.sec;
      end
    end
  end
endmodule

// File: rtl/tod_capture.sv
module tod_capture
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_fire,
  input  tod_t       cur,
  input  logic [1:0] clr,
  output tod_t       slot0,
  output tod_t       slot1,
  output logic [1:0] vld
);
  logic [1:0] vld_d;
  logic       ld0, ld1;

  always_comb begin
    vld_d = vld & ~clr;
    ld0   = cap_fire & ~vld_d[0];
    ld1   = cap_fire &  vld_d[0];
    vld_d = vld_d | {ld1, ld0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= 2'b00;
    else        vld <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (ld0) slot0 <= cur;
    if (ld1) slot1 <= cur;
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int STEP_NS_W   = 16,
  parameter int RST_STEP_NS = 3,
  parameter int RST_STEP_FR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              evt_in,
  output logic [SEC_W-1:0]  tod_sec,
  output logic [NS_W-1:0]   tod_ns,
  output logic [FR_W-1:0]   tod_frac
);
  logic [1:0] rst_pipe;
  logic       rst_sn;

  logic                 run_q, run_d;
  logic                 ph_q, ph_d;
  logic [2:0]           code_q, code_d;
  logic [STEP_NS_W-1:0] step_ns_q, step_ns_d;
  logic [FR_W-1:0]      step_fr_q, step_fr_d;
  logic [FR_W-1:0]      trim_q, trim_d;
  tod_t                 stg_q, stg_d;
  tod_t                 tod_q, tod_d;
  logic                 evt_q;
  logic [REG_W-1:0]     rd_q, rd_d;

  logic wr_cmd, trig, evt_rise, fire, cap_fire;
  cmd_e code_eff;
  tod_t tick, adj_res, slot0, slot1;
  logic [1:0] cap_vld, cap_clr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  assign wr_cmd   = wr_en && (wr_addr == A_CMD);
  assign trig     = wr_cmd && wr_data[0];
  assign evt_rise = evt_in && !evt_q;
  assign fire     = run_q && (trig || evt_rise);
  assign code_eff = cmd_e'(wr_cmd ? wr_data[4:2] : code_q);
  assign cap_fire = fire && (code_eff == CMD_CAP);
  assign cap_clr  = {rd_en && (rd_addr == A_CLR1), rd_en && (rd_addr == A_CLR0)};

  tod_step #(.STEP_NS_W(STEP_NS_W)) u_step (
    .cur(tod_q), .step_ns(step_ns_q), .step_fr(step_fr_q), .trim(trim_q), .nxt(tick)
  );

  tod_adjust u_adjust (
    .base(tick), .delta(stg_q), .sub(code_eff == CMD_DEC), .res(adj_res)
  );

  tod_capture u_capture (
    .clk(clk), .rst_n(rst_sn), .cap_fire(cap_fire), .cur(tod_q), .clr(cap_clr),
    .slot0(slot0), .slot1(slot1), .vld(cap_vld)
  );

  // register writes
  always_comb begin
    run_d     = run_q;
    ph_d      = ph_q;
    code_d    = code_q;
    step_ns_d = step_ns_q;
    step_fr_d = step_fr_q;
    stg_d     = stg_q;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL:    run_d = wr_data[0];
        A_CMD: begin
          ph_d   = wr_data[8];
          code_d = wr_data[4:2];
        end
        A_STEP_NS: step_ns_d = wr_data[STEP_NS_W-1:0];
        A_STEP_FH: step_fr_d[31:16] = wr_data;
        A_STEP_FL: step_fr_d[15:0]  = wr_data;
        default: begin
          if (wr_addr[4:3] == 2'b01) stg_d = tod_set_field(stg_q, wr_addr[2:0], wr_data);
        end
      endcase
    end
    if (fire && (code_eff == CMD_LOAD)) ph_d = 1'b0;
  end

  // time and trim next state
  always_comb begin
    trim_d = trim_q;
    tod_d  = tick;
    if (!run_q) begin
      tod_d = '0;
    end else if (fire) begin
      case (code_eff)
        CMD_LOAD: tod_d = stg_q;
        CMD_FREQ: trim_d = stg_q.fr;
        CMD_INC, CMD_DEC: tod_d = adj_res;
        default: tod_d = tick;
      endcase
    end
  end

  // read mux
  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      rd_d = '0;
      case (rd_addr)
        A_CTRL:    rd_d = {{(REG_W-1){1'b0}}, run_q};
        A_CMD:     rd_d = {7'b0, ph_q, 3'b0, code_q, 2'b00};
        A_STAT:    rd_d = {14'b0, cap_vld};
        A_STEP_NS: rd_d = {{(REG_W-STEP_NS_W){1'b0}}, step_ns_q};
        A_STEP_FH: rd_d = step_fr_q[31:16];
        A_STEP_FL: rd_d = step_fr_q[15:0];
        default: begin
          if (rd_addr[4])                  rd_d = tod_field(rd_addr[3] ? slot1 : slot0, rd_addr[2:0]);
          else if (rd_addr[4:3] == 2'b01)  rd_d = tod_field(stg_q, rd_addr[2:0]);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      run_q     <= 1'b0;
      ph_q      <= 1'b0;
      code_q    <= CMD_NOP;
      step_ns_q <= STEP_NS_W'(RST_STEP_NS);
      step_fr_q <= FR_W'(RST_STEP_FR);
      trim_q    <= '0;
      stg_q     <= '0;
      tod_q     <= '0;
      evt_q     <= 1'b0;
      rd_q      <= '0;
    end else begin
      run_q     <= run_d;
      ph_q      <= ph_d;
      code_q    <= code_d;
      step_ns_q <= step_ns_d;
      step_fr_q <= step_fr_d;
      trim_q    <= trim_d;
      stg_q     <= stg_d;
      tod_q     <= tod_d;
      evt_q     <= evt_in;
      rd_q      <= rd_d;
    end
  end

  assign rd_data  = rd_q;
  assign tod_sec  = tod_q.sec;
  assign tod_ns   = tod_q.ns;
  assign tod_frac = tod_q.fr;
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk
  import tod_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             trig,
  input logic             evt_in,
  input logic             fire,
  input logic             cap_fire,
  input logic [1:0]       clr,
  input logic [1:0]       vld,
  input logic [SEC_W-1:0] tod_sec,
  input logic [NS_W-1:0]  tod_ns,
  input logic [FR_W-1:0]  tod_frac
);
  p_hold_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (tod_sec == '0 && tod_ns == '0 && tod_frac == '0));

  p_ns_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tod_ns < NS_W'(NS_PER_SEC));

  p_evt_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && evt_in && $past(evt_in) && !trig) |-> !fire);

  p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_fire && clr == 2'b00) |=> $stable(vld));

  p_cap_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && vld == 2'b00 && clr == 2'b00) |=> (vld == 2'b01));

  p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[1] && !cap_fire) |=> !vld[1]);
endmodule

bind tod_counter tod_counter_chk u_chk (
  .clk(clk), .rst_n(rst_sn), .run(run_q), .trig(trig), .evt_in(evt_in),
  .fire(fire), .cap_fire(cap_fire), .clr(cap_clr), .vld(cap_vld),
  .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_frac(tod_frac)
);

// File: tb/tb_tod_counter.sv
`timescale 1ns/1ps
module tb_tod_counter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en, evt_in;
  logic [4:0]  wr_addr, rd_addr;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic [47:0] tod_sec;
  logic [31:0] tod_ns, tod_frac;

  int n_chk = 0;
  int n_fail = 0;
  localparam longint BIL = 64'd1_000_000_000;

  always #2 clk = ~clk;

  tod_counter dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .evt_in(evt_in),
    .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_frac(tod_frac)
  );

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(logic [4:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic stage(longint s, longint n, logic [31:0] f);
    wr(5'd8,  s[47:32]); wr(5'd9,  s[31:16]); wr(5'd10, s[15:0]);
    wr(5'd11, n[31:16]); wr(5'd12, n[15:0]);
    wr(5'd13, f[31:16]); wr(5'd14, f[15:0]);
  endtask

  function automatic longint now_ns();
    return longint'(tod_sec) * BIL + longint'(tod_ns);
  endfunction

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 sec after reset", tod_sec, 0);
    check("R1 ns after reset", tod_ns, 0);
    rd(5'd0, d); check("R1 ctrl reset", d, 0);
    rd(5'd2, d); check("R1 status reset", d, 0);
    rd(5'd3, d); check("R1 step ns reset", d, 3);
    rd(5'd5, d); check("R1 step frac reset", d, 0);
    stage(7, 100, 0);
    wr(5'd1, 16'h0001);
    wait_clk(3);
    check("R1 load ignored while stopped sec", tod_sec, 0);
    check("R1 load ignored while stopped ns", tod_ns, 0);
  endtask

  task automatic t_tick();
    longint t0;
    wr(5'd0, 16'h0001);
    wait_clk(2);
    t0 = now_ns();
    wait_clk(10);
    check("R2 ten nominal steps", now_ns() - t0, 30);
    check("R2 fraction stays zero", tod_frac, 0);
  endtask

  task automatic t_load_wrap();
    stage(5, 999_999_990, 0);
    wr(5'd1, 16'h0001);
    check("R5 load sec", tod_sec, 5);
    check("R5 load ns", tod_ns, 999_999_990);
    wait_clk(4);
    check("R3 carry sec", tod_sec, 6);
    check("R3 wrapped ns", tod_ns, 2);
  endtask

  task automatic t_frac_step();
    wr(5'd3, 16'd4); wr(5'd4, 16'hC000); wr(5'd5, 16'h0000);
    stage(0, 0, 0);
    wr(5'd1, 16'h0001);
    wait_clk(4);
    check("R2 3.75ns step x4 ns", tod_ns, 15);
    check("R2 3.75ns step x4 frac", tod_frac, 0);
    wait_clk(1);
    check("R2 3.75ns step x5 ns", tod_ns, 18);
    check("R2 3.75ns step x5 frac", tod_frac, 32'hC000_0000);
    wr(5'd3, 16'd3); wr(5'd4, 16'h0000);
  endtask

  task automatic t_freq();
    stage(0, 0, 32'h4000_0000);
    wr(5'd1, 16'h0005);              // code 1 trim
    stage(0, 100, 0);
    wr(5'd1, 16'h0001);              // load
    wait_clk(4);
    check("R6 trimmed step ns", tod_ns, 113);
    check("R6 trimmed step frac", tod_frac, 0);
    wr(5'd1, 16'h0005);              // staged frac 0 removes trim
    wr(5'd1, 16'h0001);
    wait_clk(4);
    check("R6 trim removed", tod_ns, 112);
  endtask

  task automatic t_incdec();
    longint t, e;
    stage(10, 500, 0);
    wr(5'd1, 16'h0001);
    stage(1, 999_999_999, 0);
    t = now_ns();
    wr(5'd1, 16'h0009);              // code 2 add
    e = t + 3 + BIL + 999_999_999;
    check("R7 add with carry sec", tod_sec, e / BIL);
    check("R7 add with carry ns", tod_ns, e % BIL);
    stage(3, 999_999_990, 0);
    t = now_ns();
    wr(5'd1, 16'h000D);              // code 3 subtract
    e = t + 3 - 3 * BIL - 999_999_990;
    check("R7 subtract with borrow sec", tod_sec, e / BIL);
    check("R7 subtract with borrow ns", tod_ns, e % BIL);
  endtask

  task automatic t_codes();
    longint t;
    logic [15:0] d;
    t = now_ns();
    wr(5'd1, 16'h011D);              // code 7, phase flag, trigger
    check("R11 code 7 only steps", now_ns() - t, 3);
    rd(5'd1, d);
    check("R4 cmd readback, trigger not stored", d, 16'h011C);
    t = now_ns();
    wr(5'd1, 16'h0015);              // code 5
    check("R11 code 5 only steps", now_ns() - t, 3);
    wr(5'd1, 16'h011C);
    wr(5'd1, 16'h0101);              // load, phase flag written then cleared
    rd(5'd1, d);
    check("R5 load clears phase flag", d, 16'h0000);
  endtask

  task automatic t_event();
    longint t;
    logic [15:0] d, h;
    wr(5'd1, 16'h0010);              // code 4 capture, no trigger
    t = now_ns();
    evt_in = 1'b1;
    wait_clk(6);
    rd(5'd2, d);
    check("R8 one capture from held event", d, 16'h0001);
    rd(5'd19, h); rd(5'd20, d);
    check("R8 event capture time", {h, d}, t % BIL);
    evt_in = 1'b0;
    rd(5'd22, d);
    rd(5'd2, d);
    check("R10 slot 0 cleared by frac read", d, 0);
  endtask

  task automatic t_capture();
    longint t0, t1, t2;
    logic [15:0] d, h;
    t0 = now_ns(); wr(5'd1, 16'h0011);
    t1 = now_ns(); wr(5'd1, 16'h0011);
    rd(5'd2, d);
    check("R9 both slots valid", d, 16'h0003);
    rd(5'd27, h); rd(5'd28, d);
    check("R9 slot 1 second capture", {h, d}, t1 % BIL);
    t2 = now_ns(); wr(5'd1, 16'h0011);
    rd(5'd27, h); rd(5'd28, d);
    check("R9 full capture overwrites slot 1", {h, d}, t2 % BIL);
    rd(5'd19, h); rd(5'd20, d);
    check("R9 slot 0 keeps first capture", {h, d}, t0 % BIL);
    rd(5'd30, d);
    rd(5'd2, d);
    check("R10 slot 1 cleared, slot 0 kept", d, 16'h0001);
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; evt_in = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_tick();
    t_load_wrap();
    t_frac_step();
    t_freq();
    t_incdec();
    t_codes();
    t_event();
    t_capture();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule